// File: doc/BRIEF.md
# Sum-of-Products Logic Cell Chain

This block is a row of configurable logic cells, each built around five product terms. Every cell sees one shared input bus, made of a global part and a regional part. Each term is the AND of any chosen set of true or inverted bus bits. Per-term configuration steers each term either into the cell's OR gate or to a control role: synchronous clear, clock enable, or an auxiliary signal used by the XOR stage and the JK logic.

Each cell's OR sum also takes in the running sum of the cell below it and passes the combined sum upward. A chain of eight cells can therefore form a single sum of up to forty terms. An XOR stage then sets the output polarity, or inverts under a product term. The XOR result either drives the output directly or feeds a register that acts as a D, T or JK flip-flop.

Configuration is a single flat vector. It is loaded serially before operation and then left alone while the chain runs.

Top module: `pt_cell_chain`

## Requirements
- R1: Each cycle with `cfg_shift` high shifts `cfg_si` into the top bit of the configuration vector and moves every other bit down by one, so after CFG_W shifts the first bit sent sits at bit 0. Cell c owns bits [c*174 +: 174]. Term t of a cell starts at offset t*34 and holds a true-literal mask in [15:0], an inverted-literal mask in [31:16] and a role in [33:32]. The XOR source sits at offset 170 and the mode at offset 172, two bits each.
- R2: The input bus is {rgn_in, glb_in}, with glb_in on bits [7:0]. A product term is 1 when every bus bit selected in its true mask is 1 and every bus bit selected in its inverted mask is 0. A term with empty masks is 1, and a term that selects both polarities of one bit is 0.
- R3: Role code 0 sends a term to the OR gate, 1 to clear, 2 to clock enable and 3 to auxiliary. A term with a nonzero role does not contribute to the OR sum.
- R4: chain_out[c] is the OR of cell c's OR-role terms and chain_out[c-1]. Cell 0 has no cascade input, so eight cells form one sum of up to forty terms.
- R5: The auxiliary signal is the OR of a cell's auxiliary-role terms, and it is 0 when there are none. The second XOR input is 0 for source code 0, 1 for code 1, and the auxiliary signal for codes 2 and 3. The XOR result x is chain_out[c] XOR that input.
- R6: In mode 0 (combinational), cell_out[c] equals x in the same cycle.
- R7: In mode 1 (D), the cell register loads x at the rising edge, and cell_out[c] shows the register.
- R8: In mode 2 (T), the register loads its own value XOR x.
- R9: In mode 3 (JK), with J = x and K = the auxiliary signal, the register loads J·~Q | ~K·Q.
- R10: If any clear-role term of a registered cell is 1, the register loads 0 at the edge, whatever the clock enable is.
- R11: The clock enable is the AND of a cell's enable-role terms, and it is 1 when there are none. When it is 0 and clear is inactive, the register holds its value.
- R12: While rst_n is low, every cell register is 0, so registered cells drive 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the cell registers |
| cfg_shift | input | 1 | Shift enable for the configuration vector |
| cfg_si | input | 1 | Serial configuration data |
| glb_in | input | 8 | Global part of the shared input bus |
| rgn_in | input | 8 | Regional part of the shared input bus |
| chain_out | output | 8 | Cascaded OR sum of each cell |
| cell_out | output | 8 | Output of each cell after the XOR and output select |

## Verification
The chain sums and the outputs of combinational cells depend only on the present inputs and configuration, so they are due in the same cycle the bus changes. Registered cell outputs change one rising edge after the inputs that produced them. The bench drives the bus on the falling edge and compares every output 1 ns before the next rising edge. Its model advances the register image exactly once per rising edge, so each registered result is compared in the cycle after its cause.

// File: rtl/pt_cell_pkg.sv
package pt_cell_pkg;

    typedef enum logic [1:0] {
        ROLE_OR  = 2'd0,
        ROLE_CLR = 2'd1,
        ROLE_CE  = 2'd2,
        ROLE_AUX = 2'd3
    } term_role_e;

    typedef enum logic [1:0] {
        MODE_COMB = 2'd0,
        MODE_D    = 2'd1,
        MODE_T    = 2'd2,
        MODE_JK   = 2'd3
    } cell_mode_e;

    typedef enum logic [1:0] {
        XS_LOW  = 2'd0,
        XS_HIGH = 2'd1,
        XS_AUX  = 2'd2,
        XS_AUXB = 2'd3
    } xor_src_e;

endpackage

// File: rtl/pt_cfg_shreg.sv
module pt_cfg_shreg #(
    parameter int CFG_W = 1392
) (
    input  logic             clk,
    input  logic             shift_en,
    input  logic             ser_in,
    output logic [CFG_W-1:0] cfg_o
);
    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (shift_en) begin
            cfg_d = {ser_in, cfg_q[CFG_W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/pt_and_array.sv
module pt_and_array #(
    parameter int BUS_W = 16,
    parameter int TERMS = 5
) (
    input  logic [BUS_W-1:0]       bus,
    input  logic [TERMS*BUS_W-1:0] true_mask,
    input  logic [TERMS*BUS_W-1:0] inv_mask,
    output logic [TERMS-1:0]       terms
);
    for (genvar t = 0; t < TERMS; t++) begin : g_term
        logic [BUS_W-1:0] miss;
        // a literal misses when its selected polarity disagrees with the bus
        assign miss = (true_mask[t*BUS_W +: BUS_W] & ~bus) |
                      (inv_mask[t*BUS_W +: BUS_W]  &  bus);
        assign terms[t] = ~|miss;
    end
endmodule

// File: rtl/pt_macrocell.sv
module pt_macrocell
    import pt_cell_pkg::*;
#(
    parameter int BUS_W = 16,
    parameter int TERMS = 5,
    localparam int TERM_CW = 2 * BUS_W + 2,
    localparam int CELL_CW = TERMS * TERM_CW + 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BUS_W-1:0]   bus,
    input  logic [CELL_CW-1:0] cell_cfg,
    input  logic               casc_in,
    output logic               casc_out,
    output logic               cell_out,
    output logic               clr_o,
    output logic               ce_o,
    output logic               is_reg_o
);
    typedef struct packed {
        logic q;
    } cell_st_t;

    logic [TERMS*BUS_W-1:0] tmask, imask;
    term_role_e             role [TERMS];
    logic [TERMS-1:0]       pterm;
    xor_src_e               xsrc;
    cell_mode_e             mode;

    for (genvar t = 0; t < TERMS; t++) begin : g_dec
        assign tmask[t*BUS_W +: BUS_W] = cell_cfg[t*TERM_CW +: BUS_W];
        assign imask[t*BUS_W +: BUS_W] = cell_cfg[t*TERM_CW + BUS_W +: BUS_W];
        assign role[t] = term_role_e'(cell_cfg[t*TERM_CW + 2*BUS_W +: 2]);
    end
    assign xsrc = xor_src_e'(cell_cfg[TERMS*TERM_CW +: 2]);
    assign mode = cell_mode_e'(cell_cfg[TERMS*TERM_CW + 2 +: 2]);

    pt_and_array #(
        .BUS_W (BUS_W),
        .TERMS (TERMS)
    ) and_i (
        .bus       (bus),
        .true_mask (tmask),
        .inv_mask  (imask),
        .terms     (pterm)
    );

    cell_st_t st_d, st_q;
    logic or_local, clr, ce, aux, sum, xin, x, nxt;

    always_comb begin
        or_local = 1'b0;
        clr      = 1'b0;
        ce       = 1'b1;
        aux      = 1'b0;
        for (int t = 0; t < TERMS; t++) begin
            case (role[t])
                ROLE_OR:  or_local = or_local | pterm[t];
                ROLE_CLR: clr      = clr | pterm[t];
                ROLE_CE:  ce       = ce & pterm[t];
                default:  aux      = aux | pterm[t];
            endcase
        end

        sum = or_local | casc_in;

        case (xsrc)
            XS_LOW:  xin = 1'b0;
            XS_HIGH: xin = 1'b1;
            default: xin = aux;
        endcase
        x = sum ^ xin;

        case (mode)
            MODE_T:  nxt = st_q.q ^ x;
            MODE_JK: nxt = (x & ~st_q.q) | (~aux & st_q.q);
            default: nxt = x;
        endcase

        st_d = st_q;
        if (clr) begin
            st_d.q = 1'b0;
        end else if (ce) begin
            st_d.q = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign casc_out = sum;
    assign cell_out = (mode == MODE_COMB) ? x : st_q.q;
    assign clr_o    = clr;
    assign ce_o     = ce;
    assign is_reg_o = (mode != MODE_COMB);
endmodule

// File: rtl/pt_cell_chain.sv
module pt_cell_chain #(
    parameter int GLB_W = 8,
    parameter int RGN_W = 8,
    parameter int TERMS = 5,
    parameter int CELLS = 8,
    localparam int BUS_W   = GLB_W + RGN_W,
    localparam int TERM_CW = 2 * BUS_W + 2,
    localparam int CELL_CW = TERMS * TERM_CW + 4,
    localparam int CFG_W   = CELLS * CELL_CW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_shift,
    input  logic             cfg_si,
    input  logic [GLB_W-1:0] glb_in,
    input  logic [RGN_W-1:0] rgn_in,
    output logic [CELLS-1:0] chain_out,
    output logic [CELLS-1:0] cell_out
);
    logic [CFG_W-1:0] cfg_flat;
    logic [BUS_W-1:0] bus;
    logic [CELLS-1:0] clr_v, ce_v, reg_v;

    assign bus = {rgn_in, glb_in};

    pt_cfg_shreg #(
        .CFG_W (CFG_W)
    ) cfg_i (
        .clk      (clk),
        .shift_en (cfg_shift),
        .ser_in   (cfg_si),
        .cfg_o    (cfg_flat)
    );

    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        logic casc;
        if (c == 0) begin : g_first
            assign casc = 1'b0;
        end else begin : g_next
            assign casc = chain_out[c-1];
        end

        pt_macrocell #(
            .BUS_W (BUS_W),
            .TERMS (TERMS)
        ) cell_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .bus      (bus),
            .cell_cfg (cfg_flat[c*CELL_CW +: CELL_CW]),
            .casc_in  (casc),
            .casc_out (chain_out[c]),
            .cell_out (cell_out[c]),
            .clr_o    (clr_v[c]),
            .ce_o     (ce_v[c]),
            .is_reg_o (reg_v[c])
        );
    end
endmodule

// File: rtl/pt_cell_chain_chk.sv
module pt_cell_chain_chk #(
    parameter int CELLS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_shift,
    input logic             cfg_si,
    input logic             cfg_msb,
    input logic [CELLS-1:0] chain_out,
    input logic [CELLS-1:0] cell_out,
    input logic [CELLS-1:0] clr_v,
    input logic [CELLS-1:0] ce_v,
    input logic [CELLS-1:0] reg_v
);
    // R1
    cfg_shift_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_shift |=> (cfg_msb == $past(cfg_si)));

    // R12
    always @(posedge clk) begin
        if (!rst_n && !$isunknown(reg_v)) begin
            reset_zero_chk: assert ((cell_out & reg_v) == '0);
        end
    end

    for (genvar c = 0; c < CELLS; c++) begin : g_chk
        if (c > 0) begin : g_casc
            // R4
            chain_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
                chain_out[c-1] |-> chain_out[c]);
        end

        // R10
        clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_v[c] && clr_v[c] && !cfg_shift) |=> !cell_out[c]);

        // R11
        enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_v[c] && !clr_v[c] && !ce_v[c] && !cfg_shift) |=> $stable(cell_out[c]));
    end
endmodule

bind pt_cell_chain pt_cell_chain_chk #(
    .CELLS (CELLS)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_shift (cfg_shift),
    .cfg_si    (cfg_si),
    .cfg_msb   (cfg_flat[CFG_W-1]),
    .chain_out (chain_out),
    .cell_out  (cell_out),
    .clr_v     (clr_v),
    .ce_v      (ce_v),
    .reg_v     (reg_v)
);

// File: tb/pt_cell_chain_tb_top.sv
`timescale 1ns/1ps
module pt_cell_chain_tb_top;
    localparam int NC   = 8;
    localparam int NT   = 5;
    localparam int NB   = 16;
    localparam int TW   = 2 * NB + 2;
    localparam int CW   = NT * TW + 4;
    localparam int CFGW = NC * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_shift = 1'b0;
    logic          cfg_si = 1'b0;
    logic [7:0]    glb_in = '0;
    logic [7:0]    rgn_in = '0;
    logic [NC-1:0] chain_out, cell_out;

    always #5 clk = ~clk;

    pt_cell_chain dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_shift (cfg_shift),
        .cfg_si    (cfg_si),
        .glb_in    (glb_in),
        .rgn_in    (rgn_in),
        .chain_out (chain_out),
        .cell_out  (cell_out)
    );

    // bench image of the configuration
    logic [NB-1:0] tm [NC][NT];
    logic [NB-1:0] im [NC][NT];
    logic [1:0]    rl [NC][NT];
    logic [1:0]    xs [NC];
    logic [1:0]    md [NC];
    logic          mq [NC];
    string         qtag [NC];
    string         dir_tag = "";

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    task automatic check(input string tag, input string what, input int c,
                         input logic got, input logic exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s cell %0d %s got %0b expected %0b", tag, c, what, got, exp);
        end
    endtask

    function automatic logic term_val(input int c, input int t, input logic [NB-1:0] bus);
        return ((tm[c][t] & ~bus) | (im[c][t] & bus)) == '0;
    endfunction

    task automatic clear_cfg();
        for (int c = 0; c < NC; c++) begin
            for (int t = 0; t < NT; t++) begin
                tm[c][t] = 16'h0001;
                im[c][t] = 16'h0001;
                rl[c][t] = 2'd0;
            end
            xs[c] = 2'd0;
            md[c] = 2'd0;
        end
    endtask

    task automatic rand_cfg();
        for (int c = 0; c < NC; c++) begin
            for (int t = 0; t < NT; t++) begin
                int r;
                tm[c][t] = 16'($urandom & $urandom & $urandom);
                im[c][t] = 16'($urandom & $urandom & $urandom) & ~tm[c][t];
                r = int'($urandom % 8);
                rl[c][t] = (r < 5) ? 2'd0 : 2'(r - 4);
            end
            xs[c] = 2'($urandom % 4);
            md[c] = 2'($urandom % 4);
        end
    endtask

    // sends bit 0 first (R1 layout)
    task automatic load_cfg();
        logic [CFGW-1:0] f;
        f = '0;
        for (int c = 0; c < NC; c++) begin
            for (int t = 0; t < NT; t++) begin
                f[c*CW + t*TW +: NB]      = tm[c][t];
                f[c*CW + t*TW + NB +: NB] = im[c][t];
                f[c*CW + t*TW + 2*NB +: 2] = rl[c][t];
            end
            f[c*CW + NT*TW +: 2]     = xs[c];
            f[c*CW + NT*TW + 2 +: 2] = md[c];
        end
        for (int i = 0; i < CFGW; i++) begin
            cfg_shift = 1'b1;
            cfg_si    = f[i];
            @(negedge clk);
        end
        cfg_shift = 1'b0;
        cfg_si    = 1'b0;
    endtask

    task automatic reset_dut();
        rst_n = 1'b0;
        @(negedge clk);
        #4;
        for (int c = 0; c < NC; c++) begin
            if (md[c] != 2'd0) check("R12", "out in reset", c, cell_out[c], 1'b0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        for (int c = 0; c < NC; c++) begin
            mq[c]   = 1'b0;
            qtag[c] = "R12";
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic step(input logic [7:0] g, input logic [7:0] r);
        logic [NB-1:0] bus;
        logic prev;
        glb_in = g;
        rgn_in = r;
        bus = {r, g};
        #4;
        prev = 1'b0;
        for (int c = 0; c < NC; c++) begin
            logic orl, clr, ce, aux, sum, xin, x, nxt, eo;
            string tag;
            orl = 1'b0; clr = 1'b0; ce = 1'b1; aux = 1'b0;
            for (int t = 0; t < NT; t++) begin
                logic p;
                p = term_val(c, t, bus);
                case (rl[c][t])
                    2'd0: orl = orl | p;
                    2'd1: clr = clr | p;
                    2'd2: ce  = ce & p;
                    default: aux = aux | p;
                endcase
            end
            sum  = orl | prev;
            prev = sum;
            xin  = (xs[c] == 2'd0) ? 1'b0 : (xs[c] == 2'd1) ? 1'b1 : aux;
            x    = sum ^ xin;
            check((dir_tag != "") ? dir_tag : "R4", "chain", c, chain_out[c], sum);
            if (md[c] == 2'd0) begin
                eo  = x;
                tag = (xs[c] >= 2'd2) ? "R5" : "R6";
            end else begin
                eo  = mq[c];
                tag = qtag[c];
            end
            check((dir_tag != "") ? dir_tag : tag, "out", c, cell_out[c], eo);
            case (md[c])
                2'd2:    nxt = mq[c] ^ x;
                2'd3:    nxt = (x & ~mq[c]) | (~aux & mq[c]);
                default: nxt = x;
            endcase
            if (clr) begin
                mq[c] = 1'b0;  qtag[c] = "R10";
            end else if (!ce) begin
                qtag[c] = "R11";
            end else begin
                mq[c]   = nxt;
                qtag[c] = (md[c] == 2'd1) ? "R7" : (md[c] == 2'd2) ? "R8" : "R9";
            end
        end
        @(negedge clk);
    endtask

    task automatic run_rand(input int n);
        for (int i = 0; i < n; i++) step(8'($urandom), 8'($urandom));
    endtask

    initial begin
        void'($urandom(32'h5eed_0c11));
        @(negedge clk);

        // R2 / R4: all terms contradictory, one empty term in cell 3 lifts cells 3..7
        clear_cfg();
        tm[3][4] = '0; im[3][4] = '0;
        load_cfg(); reset_dut();
        dir_tag = "R2"; run_rand(4);
        dir_tag = "R4"; run_rand(4);

        // R3: same empty term steered to clear must leave every sum at 0
        rl[3][4] = 2'd1;
        load_cfg(); reset_dut();
        dir_tag = "R3"; run_rand(4);

        // R1: distinct polarity per cell exposes shift order
        clear_cfg();
        for (int c = 0; c < NC; c++) xs[c] = 2'(c % 2);
        tm[0][0] = 16'h0100; im[0][0] = 16'h0000;
        load_cfg(); reset_dut();
        dir_tag = "R1"; step(8'h00, 8'h01); step(8'h00, 8'h00); run_rand(4);

        // R8 / R9: constant toggles, T via polarity, JK via J=K=1
        clear_cfg();
        md[0] = 2'd2; xs[0] = 2'd1;
        md[1] = 2'd3; tm[1][0] = '0; im[1][0] = '0; tm[1][1] = '0; im[1][1] = '0;
        rl[1][1] = 2'd3;
        md[2] = 2'd1; tm[2][2] = 16'h0001; im[2][2] = '0; rl[2][2] = 2'd2;
        load_cfg(); reset_dut();
        dir_tag = "";
        step(8'h00, 8'h00); step(8'h01, 8'h00); step(8'h00, 8'h00); step(8'h01, 8'h00);
        run_rand(8);

        // random configurations and inputs
        for (int k = 0; k < 25; k++) begin
            rand_cfg();
            load_cfg(); reset_dut();
            step(8'h00, 8'h00);
            step(8'hff, 8'hff);
            run_rand(40);
        end

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired got running expected finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule